// File: doc/BRIEF.md
# FIFO Threshold Interrupt Generator

This block holds the transmit and receive word queues of a serial port controller and turns their fill levels into interrupt requests. Both queues share a fixed byte budget (16 bytes by default). The selected word width of 8, 16 or 32 bits sets how many entries fit. Each word is stored with only the bits of the current width kept. The bus side and the serial shifter sit outside the block and reach it through push and pop strobes.

Each direction has a level-sensitive interrupt request. A 2-bit mode picks the condition that drives it. The receive side also keeps a sticky overflow flag. The flag raises a fault request when that request is enabled, and the receive side shows when its queue is empty. Changing the word width discards the contents of both queues.

Top module: `fifo_thresh_irq`

## Requirements
- R1: The depth in entries is FIFO_BYTES divided by the word size in bytes. Width code 0 gives 8-bit words (16 entries), code 1 gives 16-bit words (8 entries), and codes 2 and 3 give 32-bit words (4 entries). A stored word keeps only its low 8, 16 or 32 bits, and the upper bits read as zero.
- R2: Each queue returns words in the order they were pushed. The read data port always shows the oldest stored word, or zero when the queue is empty.
- R3: A receive push with no pop while the receive queue is full discards the word, keeps the stored contents, and sets rx_ovf_o on the next edge. The flag stays set until ovf_clr_i. A new overflow in the same cycle as the clear leaves the flag set. A push together with a pop on a full queue is accepted without overflow.
- R4: fault_irq_o is high exactly while rx_ovf_o and fault_en_i are both high.
- R5: The receive request rx_irq_o follows rx_mode_i. Mode 0 fires at level 0, mode 1 at level not 0, mode 2 at level of at least half the depth, and mode 3 at level equal to the depth.
- R6: The transmit request tx_irq_o follows tx_mode_i. Mode 0 fires at level 0 with tx_busy_i low, mode 1 at level 0, mode 2 when the free entries are at least half the depth, and mode 3 when at least one entry is free.
- R7: tx_level_o and rx_level_o give the entry count and change on the edge after an accepted push or pop. A pop on an empty queue and a transmit push on a full queue leave the level unchanged and set no flag.
- R8: rx_empty_o is high exactly when the receive level is 0.
- R9: When width_sel_i differs from its value on the previous edge, both levels are 0 after the next edge. Pushes in that cycle are dropped, and rx_ovf_o keeps its value.
- R10: After reset both levels are 0, rx_empty_o is 1, rx_ovf_o and fault_irq_o are 0, and the width is 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| width_sel_i | input | 2 | Word width code |
| rx_mode_i | input | 2 | Receive interrupt condition |
| tx_mode_i | input | 2 | Transmit interrupt condition |
| fault_en_i | input | 1 | Fault request enable |
| tx_push_i | input | 1 | Write a word into the transmit queue |
| tx_wdata_i | input | DATA_W | Transmit word to store |
| tx_pop_i | input | 1 | Shifter takes the oldest transmit word |
| tx_busy_i | input | 1 | Shifter still holds a word |
| tx_rdata_o | output | DATA_W | Oldest transmit word |
| rx_push_i | input | 1 | Shifter delivers a received word |
| rx_wdata_i | input | DATA_W | Received word |
| rx_pop_i | input | 1 | Bus reads the oldest received word |
| rx_rdata_o | output | DATA_W | Oldest received word |
| ovf_clr_i | input | 1 | Clear the overflow flag |
| tx_level_o | output | $clog2(FIFO_BYTES)+1 | Transmit entry count |
| rx_level_o | output | $clog2(FIFO_BYTES)+1 | Receive entry count |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_ovf_o | output | 1 | Sticky receive overflow |
| tx_irq_o | output | 1 | Transmit interrupt request |
| rx_irq_o | output | 1 | Receive interrupt request |
| fault_irq_o | output | 1 | Fault interrupt request |

## Verification
A wrong pointer or level register shows up at the ports on the edge after the faulty push or pop. The level outputs and all four interrupt conditions read it directly, and the read data ports show the wrong word at once. A depth decoded for the wrong width is exposed the first time a queue is filled to its limit, because the overflow flag either sets early or never sets. Sweeping every width through fill, overflow, drain and empty-pop, and checking every mode at every level, brings each such fault out within a few cycles.

// File: rtl/fifo_thresh_irq_pkg.sv
package fifo_thresh_irq_pkg;
  // log2 of the word size in bytes for a width code
  function automatic int unsigned width_shift(logic [1:0] w);
    case (w)
      2'd0:    return 0;
      2'd1:    return 1;
      default: return 2;
    endcase
  endfunction
endpackage

// File: rtl/fti_fifo.sv
module fti_fifo #(
  parameter int DATA_W  = 32,
  parameter int ENTRIES = 16,
  localparam int PW = $clog2(ENTRIES),
  localparam int LW = PW + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic [LW-1:0]     depth_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] data_o,
  output logic [LW-1:0]     level_o
);
  logic [DATA_W-1:0] mem [ENTRIES];
  logic [PW-1:0]     wr_q, rd_q;
  logic [LW-1:0]     level_q;
  logic              full, empty, push_ok, pop_ok;

  function automatic logic [PW-1:0] nxt(logic [PW-1:0] p, logic [LW-1:0] d);
    if ({1'b0, p} == d - LW'(1)) return '0;
    return p + PW'(1);
  endfunction

  assign full    = (level_q == depth_i);
  assign empty   = (level_q == '0);
  assign push_ok = push_i & ~flush_i & (~full | pop_i);
  assign pop_ok  = pop_i & ~flush_i & ~empty;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else if (flush_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_ok) wr_q <= nxt(wr_q, depth_i);
      if (pop_ok)  rd_q <= nxt(rd_q, depth_i);
      level_q <= level_q + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem[wr_q] <= data_i;
  end

  assign data_o  = empty ? '0 : mem[rd_q];
  assign level_o = level_q;
endmodule

// File: rtl/fti_rx_thresh.sv
module fti_rx_thresh #(
  parameter int LW = 5
) (
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] depth_i,
  input  logic [1:0]    mode_i,
  output logic          irq_o
);
  logic [LW-1:0] half;
  assign half = depth_i >> 1;

  always_comb begin
    case (mode_i)
      2'd0:    irq_o = (level_i == '0);
      2'd1:    irq_o = (level_i != '0);
      2'd2:    irq_o = (level_i >= half);
      default: irq_o = (level_i == depth_i);
    endcase
  end
endmodule

// File: rtl/fti_tx_thresh.sv
module fti_tx_thresh #(
  parameter int LW = 5
) (
  input  logic [LW-1:0] level_i,
  input  logic [LW-1:0] depth_i,
  input  logic [1:0]    mode_i,
  input  logic          busy_i,
  output logic          irq_o
);
  logic [LW-1:0] half, free;
  assign half = depth_i >> 1;
  assign free = depth_i - level_i;

  always_comb begin
    case (mode_i)
      2'd0:    irq_o = (level_i == '0) & ~busy_i;
      2'd1:    irq_o = (level_i == '0);
      2'd2:    irq_o = (free >= half);
      default: irq_o = (free != '0);
    endcase
  end
endmodule

// File: rtl/fifo_thresh_irq.sv
module fifo_thresh_irq
  import fifo_thresh_irq_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  parameter int DATA_W     = 32,
  localparam int LW = $clog2(FIFO_BYTES) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        width_sel_i,
  input  logic [1:0]        rx_mode_i,
  input  logic [1:0]        tx_mode_i,
  input  logic              fault_en_i,
  input  logic              tx_push_i,
  input  logic [DATA_W-1:0] tx_wdata_i,
  input  logic              tx_pop_i,
  input  logic              tx_busy_i,
  output logic [DATA_W-1:0] tx_rdata_o,
  input  logic              rx_push_i,
  input  logic [DATA_W-1:0] rx_wdata_i,
  input  logic              rx_pop_i,
  output logic [DATA_W-1:0] rx_rdata_o,
  input  logic              ovf_clr_i,
  output logic [LW-1:0]     tx_level_o,
  output logic [LW-1:0]     rx_level_o,
  output logic              rx_empty_o,
  output logic              rx_ovf_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              fault_irq_o
);
  logic [1:0]        width_q;
  logic              flush;
  logic [LW-1:0]     depth;
  logic [DATA_W-1:0] wmask;
  logic              ovf_q, rx_drop;

  assign flush = (width_sel_i != width_q);
  assign depth = LW'(FIFO_BYTES >> width_shift(width_q));

  always_comb begin
    case (width_q)
      2'd0:    wmask = DATA_W'({8{1'b1}});
      2'd1:    wmask = DATA_W'({16{1'b1}});
      default: wmask = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) width_q <= '0;
    else         width_q <= width_sel_i;
  end

  fti_fifo #(.DATA_W(DATA_W), .ENTRIES(FIFO_BYTES)) u_tx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .depth_i (depth),
    .push_i  (tx_push_i),
    .data_i  (tx_wdata_i & wmask),
    .pop_i   (tx_pop_i),
    .data_o  (tx_rdata_o),
    .level_o (tx_level_o)
  );

  fti_fifo #(.DATA_W(DATA_W), .ENTRIES(FIFO_BYTES)) u_rx_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .depth_i (depth),
    .push_i  (rx_push_i),
    .data_i  (rx_wdata_i & wmask),
    .pop_i   (rx_pop_i),
    .data_o  (rx_rdata_o),
    .level_o (rx_level_o)
  );

  fti_tx_thresh #(.LW(LW)) u_tx_thr (
    .level_i (tx_level_o),
    .depth_i (depth),
    .mode_i  (tx_mode_i),
    .busy_i  (tx_busy_i),
    .irq_o   (tx_irq_o)
  );

  fti_rx_thresh #(.LW(LW)) u_rx_thr (
    .level_i (rx_level_o),
    .depth_i (depth),
    .mode_i  (rx_mode_i),
    .irq_o   (rx_irq_o)
  );

  // discarded receive word: full, no pop freeing a slot, not flushing
  assign rx_drop = rx_push_i & ~rx_pop_i & ~flush & (rx_level_o == depth);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ovf_q <= 1'b0;
    else if (rx_drop)   ovf_q <= 1'b1;
    else if (ovf_clr_i) ovf_q <= 1'b0;
  end

  assign rx_ovf_o    = ovf_q;
  assign fault_irq_o = ovf_q & fault_en_i;
  assign rx_empty_o  = (rx_level_o == '0);
endmodule

// File: rtl/fifo_thresh_irq_chk.sv
module fifo_thresh_irq_chk
  import fifo_thresh_irq_pkg::*;
#(
  parameter int FIFO_BYTES = 16,
  localparam int LW = $clog2(FIFO_BYTES) + 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [1:0]    width_sel_i,
  input logic          rx_push_i,
  input logic          rx_pop_i,
  input logic          ovf_clr_i,
  input logic [LW-1:0] tx_level_o,
  input logic [LW-1:0] rx_level_o,
  input logic          rx_ovf_o
);
  function automatic int unsigned dep(logic [1:0] w);
    return FIFO_BYTES >> width_shift(w);
  endfunction

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (width_sel_i != $past(width_sel_i)) |=> (rx_level_o == '0 && tx_level_o == '0));

  p_ovf_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_ovf_o && !ovf_clr_i) |=> rx_ovf_o);

  p_ovf_set_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i && !rx_pop_i && width_sel_i == $past(width_sel_i)
     && 32'(rx_level_o) == dep(width_sel_i)) |=> rx_ovf_o);

  p_ovf_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_ovf_o) |-> $past(rx_push_i));

  p_rx_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (32'(rx_level_o) <= 32'($past(rx_level_o)) + 1));

  p_tx_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (32'(tx_level_o) <= 32'($past(tx_level_o)) + 1));
endmodule

bind fifo_thresh_irq fifo_thresh_irq_chk #(.FIFO_BYTES(FIFO_BYTES)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .width_sel_i (width_sel_i),
  .rx_push_i   (rx_push_i),
  .rx_pop_i    (rx_pop_i),
  .ovf_clr_i   (ovf_clr_i),
  .tx_level_o  (tx_level_o),
  .rx_level_o  (rx_level_o),
  .rx_ovf_o    (rx_ovf_o)
);

// File: tb/fifo_thresh_irq_tb.sv
`timescale 1ns/1ps
module fifo_thresh_irq_tb;
  localparam int FB = 16;
  localparam int DW = 32;
  localparam int LW = $clog2(FB) + 1;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [1:0] width_sel_i = '0, rx_mode_i = '0, tx_mode_i = '0;
  logic fault_en_i = 0, tx_push_i = 0, tx_pop_i = 0, tx_busy_i = 0;
  logic rx_push_i = 0, rx_pop_i = 0, ovf_clr_i = 0;
  logic [DW-1:0] tx_wdata_i = '0, rx_wdata_i = '0, tx_rdata_o, rx_rdata_o;
  logic [LW-1:0] tx_level_o, rx_level_o;
  logic rx_empty_o, rx_ovf_o, tx_irq_o, rx_irq_o, fault_irq_o;

  int checks = 0, errors = 0;
  bit done = 0;
  int cur_w = 0;
  logic [31:0] mtx[$], mrx[$];

  always #2.5 clk_i = ~clk_i;

  fifo_thresh_irq #(.FIFO_BYTES(FB), .DATA_W(DW)) u_dut (.*);

  function automatic int dep(int w);
    return (w == 0) ? FB : (w == 1) ? FB / 2 : FB / 4;
  endfunction
  function automatic logic [31:0] msk(int w);
    return (w == 0) ? 32'hFF : (w == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic logic [31:0] pat(int w, int i);
    return 32'h9E37_79B9 * (i + 1) + 32'(w);
  endfunction

  task automatic chk(string r, logic [31:0] a, logic [31:0] e);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", r, a, e);
    end
  endtask

  task automatic cyc(logic tp, logic [31:0] td, logic tpop,
                     logic rp, logic [31:0] rd, logic rpop, logic clr);
    @(negedge clk_i);
    tx_push_i = tp; tx_wdata_i = td; tx_pop_i = tpop;
    rx_push_i = rp; rx_wdata_i = rd; rx_pop_i = rpop; ovf_clr_i = clr;
    @(posedge clk_i); #1;
    tx_push_i = 0; tx_pop_i = 0; rx_push_i = 0; rx_pop_i = 0; ovf_clr_i = 0;
  endtask

  task automatic check_state();
    int d = dep(cur_w);
    int tl = mtx.size();
    int rl = mrx.size();
    chk("R7 tx level", 32'(tx_level_o), 32'(tl));
    chk("R7 rx level", 32'(rx_level_o), 32'(rl));
    chk("R8 rx empty", 32'(rx_empty_o), 32'(rl == 0));
    for (int m = 0; m < 4; m++) begin
      for (int b = 0; b < 2; b++) begin
        rx_mode_i = 2'(m); tx_mode_i = 2'(m); tx_busy_i = b[0];
        #0.1;
        case (m)
          0: begin chk("R5 rx mode0", 32'(rx_irq_o), 32'(rl == 0));
                   chk("R6 tx mode0", 32'(tx_irq_o), 32'(tl == 0 && b == 0)); end
          1: begin chk("R5 rx mode1", 32'(rx_irq_o), 32'(rl != 0));
                   chk("R6 tx mode1", 32'(tx_irq_o), 32'(tl == 0)); end
          2: begin chk("R5 rx mode2", 32'(rx_irq_o), 32'(rl >= d / 2));
                   chk("R6 tx mode2", 32'(tx_irq_o), 32'(d - tl >= d / 2)); end
          default: begin chk("R5 rx mode3", 32'(rx_irq_o), 32'(rl == d));
                   chk("R6 tx mode3", 32'(tx_irq_o), 32'(tl < d)); end
        endcase
      end
    end
    rx_mode_i = 0; tx_mode_i = 0; tx_busy_i = 0;
  endtask

  task automatic change_width(int nw);
    @(negedge clk_i);
    width_sel_i = 2'(nw);
    @(posedge clk_i); #1;
    cur_w = nw;
    mtx.delete(); mrx.delete();
    chk("R9 tx flushed", 32'(tx_level_o), 0);
    chk("R9 rx flushed", 32'(rx_level_o), 0);
    chk("R9 ovf kept", 32'(rx_ovf_o), 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R3 ovf cleared", 32'(rx_ovf_o), 0);
  endtask

  task automatic run_width(int w);
    int d = dep(w);
    logic [31:0] v;
    fault_en_i = 0;
    check_state();
    for (int i = 0; i < d; i++) begin
      cyc(1, pat(w, i) ^ 32'h5A5A_0F0F, 0, 1, pat(w, i), 0, 0);
      mtx.push_back((pat(w, i) ^ 32'h5A5A_0F0F) & msk(w));
      mrx.push_back(pat(w, i) & msk(w));
      check_state();
    end
    chk("R1 depth tx", 32'(tx_level_o), 32'(d));
    cyc(1, 32'hDEAD_BEEF, 0, 0, 0, 0, 0);
    chk("R7 tx push full ignored", 32'(tx_level_o), 32'(d));
    chk("R7 tx no flag", 32'(rx_ovf_o), 0);
    cyc(0, 0, 0, 1, 32'hCAFE_F00D, 0, 0);
    chk("R3 rx level kept", 32'(rx_level_o), 32'(d));
    chk("R3 ovf set", 32'(rx_ovf_o), 1);
    chk("R4 fault masked", 32'(fault_irq_o), 0);
    fault_en_i = 1; #0.1;
    chk("R4 fault raised", 32'(fault_irq_o), 1);
    fault_en_i = 0;
    cyc(0, 0, 0, 0, 0, 0, 1);
    chk("R3 ovf clear", 32'(rx_ovf_o), 0);
    chk("R4 fault low", 32'(fault_irq_o), 0);
    v = pat(w, 100);
    cyc(0, 0, 0, 1, v, 1, 0);
    void'(mrx.pop_front()); mrx.push_back(v & msk(w));
    chk("R3 push+pop at full no ovf", 32'(rx_ovf_o), 0);
    chk("R3 push+pop level", 32'(rx_level_o), 32'(d));
    cyc(0, 0, 0, 1, 32'h1234_5678, 0, 1);
    chk("R3 set wins over clear", 32'(rx_ovf_o), 1);
    cyc(0, 0, 0, 0, 0, 0, 1);
    while (mrx.size() > 0) begin
      chk("R2 tx order", tx_rdata_o, mtx[0]);
      chk("R2 rx order", rx_rdata_o, mrx[0]);
      chk("R1 upper bits zero", rx_rdata_o & ~msk(w), 0);
      cyc(0, 0, 1, 0, 0, 1, 0);
      void'(mtx.pop_front()); void'(mrx.pop_front());
      check_state();
    end
    cyc(0, 0, 1, 0, 0, 1, 0);
    chk("R7 empty pop tx", 32'(tx_level_o), 0);
    chk("R7 empty pop rx", 32'(rx_level_o), 0);
    chk("R2 empty data", rx_rdata_o, 0);
    for (int i = 0; i <= d; i++) cyc(i < 2, 32'(i), 0, 1, 32'(i), 0, 0);
    chk("R3 refill ovf", 32'(rx_ovf_o), 1);
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); rst_ni = 1;
    @(posedge clk_i); #1;
    chk("R10 tx level", 32'(tx_level_o), 0);
    chk("R10 rx level", 32'(rx_level_o), 0);
    chk("R10 rx empty", 32'(rx_empty_o), 1);
    chk("R10 ovf", 32'(rx_ovf_o), 0);
    chk("R10 fault", 32'(fault_irq_o), 0);
    chk("R10 rx irq mode0", 32'(rx_irq_o), 1);
    chk("R10 tx irq mode0", 32'(tx_irq_o), 1);
    for (int w = 0; w < 4; w++) begin
      if (w > 0) change_width(w);
      run_width(w);
    end
    change_width(0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=hung exp=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule